// File: doc/BRIEF.md
# Legacy NMI Mask and Fast A20 / Init Control Registers

This block is a byte-wide I/O register block for legacy system control. It decodes single-byte reads and writes at three fixed port addresses. The NMI control port holds an NMI mask bit and a 7-bit index. The index selects a location in an external real-time clock / CMOS memory, and the block drives it out with a one-cycle strobe. The mask bit gates a raw NMI request before it leaves the block.

The system control port holds a fast A20 gate bit and a software init bit. The A20 bit is combined with an external A20 gate input to form the active-low A20 mask output. When the init bit goes from 0 to 1, the block produces an active-low processor init pulse of fixed length. In normal operation the index field cannot be read back. When the alternate-access input is high, the whole NMI control byte can be read at both the NMI port and its alias port.

Top module: `legacy_sysctl_regs`

## Requirements
- R1: After reset, the NMI control byte is 80h (NMI masked, index 0) and the system control byte is 00h. During reset and afterwards, until a pulse is triggered, `init_n` is 1. Within two cycles of reset release, `nmi_out` is 0.
- R2: `nmi_out` equals `nmi_raw` AND NOT mask bit 7 of the NMI control byte. It is registered, so it reflects the input and the mask as they stood at the previous clock edge.
- R3: A write to port 70h stores bits 6:0 as the index. The cycle after the write edge, `rtc_index` shows the new index and `rtc_index_wr` is high for exactly one cycle.
- R4: With `alt_access` low, a read of port 70h returns {mask bit, 7'b0000000}, and a read of port 74h returns 00h.
- R5: With `alt_access` high, reads of port 70h and of port 74h both return the full NMI control byte.
- R6: A read of port 92h returns {6'b000000, A20 bit (bit 1), init bit (bit 0)}. Writes to bits 7:2 of port 92h have no effect.
- R7: `a20m_n` is registered and equals `a20_gate` OR the stored A20 bit, as they stood at the previous edge.
- R8: A write that changes the init bit (bit 0 of port 92h) from 0 to 1 drives `init_n` low for exactly 16 consecutive clocks, starting in the cycle after the write edge.
- R9: A write of 1 to the init bit while it already holds 1 starts no pulse. A second pulse starts only after the bit is written to 0 and then to 1.
- R10: A 0-to-1 write of the init bit while a pulse is still running neither restarts the pulse nor lengthens it.
- R11: Writes to port 74h or to any undecoded address change no register. Reads of undecoded addresses return 00h.
- R12: Read data appears on `io_rdata` in the cycle after the edge at which `io_rd` is sampled. In every other cycle `io_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Byte write strobe, one cycle per write |
| io_rd | input | 1 | Byte read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| alt_access | input | 1 | Alternate-access read mode |
| nmi_raw | input | 1 | Combined NMI request from the sources |
| nmi_out | output | 1 | Masked NMI toward the processor |
| rtc_index | output | 7 | Clock / CMOS memory index |
| rtc_index_wr | output | 1 | One-cycle strobe after each index write |
| a20_gate | input | 1 | External A20 gate input |
| a20m_n | output | 1 | Active-low A20 mask output |
| init_n | output | 1 | Active-low processor init pulse |

## Verification
Two functions can fall on the same cycle: a new 0-to-1 write of the init bit, and a pulse that is still counting down. The bench provokes this by writing 0 and then 1 to port 92h a few cycles into a running pulse. It then counts every low cycle of `init_n` and every falling edge. A correct run shows one falling edge and exactly 16 low cycles. A second case is a change of `a20_gate` in the same cycle as a write to the A20 bit. The bench judges `a20m_n` one registered cycle later against the OR of both values.

// File: rtl/legacy_sysctl_pkg.sv
// Package: shared port map and types for the legacy system control registers.
// Assumes 16-bit I/O addresses and byte-wide data.
package legacy_sysctl_pkg;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned INDEX_W    = DATA_W - 1;
    localparam logic [ADDR_W-1:0] PORT_NMI    = 16'h0070;
    localparam logic [ADDR_W-1:0] PORT_ALIAS  = 16'h0074;
    localparam logic [ADDR_W-1:0] PORT_SYSCTL = 16'h0092;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_NMI    = 2'd1,
        SEL_ALIAS  = 2'd2,
        SEL_SYSCTL = 2'd3
    } port_sel_e;

    // Map an I/O address onto one of the decoded ports.
    function automatic port_sel_e decode_port(input logic [ADDR_W-1:0] a);
        if (a == PORT_NMI)         return SEL_NMI;
        else if (a == PORT_ALIAS)  return SEL_ALIAS;
        else if (a == PORT_SYSCTL) return SEL_SYSCTL;
        else                       return SEL_NONE;
    endfunction
endpackage

// File: rtl/lsc_nmi_index.sv
// NMI mask and clock index register.
// Holds the mask bit (reset 1 = masked) and the index field, gates the raw NMI,
// and strobes the index toward the clock / CMOS interface after each write.
// Assumes wr_en is a one-cycle pulse already qualified by address decode.
module lsc_nmi_index
    import legacy_sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               nmi_raw,
    output logic [DATA_W-1:0]  reg_q,
    output logic               nmi_out,
    output logic [INDEX_W-1:0] index_q,
    output logic               index_wr
);
    logic mask_q;
    logic past_ok;

    // Store the mask bit and the index on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= 1'b1;
            index_q <= '0;
        end else if (wr_en) begin
            mask_q  <= wdata[DATA_W-1];
            index_q <= wdata[INDEX_W-1:0];
        end
    end

    // Register the masked NMI and the index write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_out  <= 1'b0;
            index_wr <= 1'b0;
        end else begin
            nmi_out  <= nmi_raw & ~mask_q;
            index_wr <= wr_en;
        end
    end

    // Track that at least one edge has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign reg_q = {mask_q, index_q};

    // R2
    nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && nmi_out) |-> ($past(nmi_raw) && !$past(mask_q)));
    // R3
    index_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && index_wr) |-> ($past(wr_en) && index_q == $past(wdata[INDEX_W-1:0])));
endmodule

// File: rtl/lsc_init_pulse.sv
// Fixed-length active-low init pulse generator.
// A start request while idle loads the counter and drives init_n low for
// PULSE_LEN clocks. A start during a running pulse is ignored.
module lsc_init_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic init_n
);
    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] remain_q;

    // Load on an idle start, else count down and release at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            init_n   <= 1'b1;
        end else if (remain_q == '0) begin
            if (start) begin
                remain_q <= LOAD;
                init_n   <= 1'b0;
            end
        end else begin
            remain_q <= remain_q - 1'b1;
            init_n   <= (remain_q == CNT_W'(1));
        end
    end

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_n) |-> (remain_q == LOAD));
    // R8
    pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> (remain_q != '0));
    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q > CNT_W'(1)) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/lsc_fast_a20_init.sv
// Fast A20 gate and software init register.
// Keeps two bits (A20, init). Reserved bits are not stored. It forms the A20
// mask output and starts an init pulse on a 0-to-1 write of the init bit.
// Assumes wr_en is a one-cycle pulse already qualified by address decode.
module lsc_fast_a20_init
    import legacy_sysctl_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              a20_gate,
    output logic [1:0]        bits_q,
    output logic              a20m_n,
    output logic              init_n
);
    logic a20_q;
    logic init_q;
    logic start;
    logic past_ok;

    assign start  = wr_en & wdata[0] & ~init_q;
    assign bits_q = {a20_q, init_q};

    // Store the two defined bits; bits 7:2 are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a20_q  <= 1'b0;
            init_q <= 1'b0;
        end else if (wr_en) begin
            a20_q  <= wdata[1];
            init_q <= wdata[0];
        end
    end

    // Register the combined A20 mask output.
    always_ff @(posedge clk) begin
        if (!rst_n) a20m_n <= 1'b1;
        else        a20m_n <= a20_gate | a20_q;
    end

    // Track that at least one edge has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    lsc_init_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .init_n (init_n)
    );

    // R7
    a20_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (a20m_n == ($past(a20_gate) | $past(a20_q))));
    // R9
    init_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(init_n)) |-> ($past(wr_en) && $past(wdata[0]) && !$past(init_q)));
endmodule

// File: rtl/lsc_read_mux.sv
// Registered read data selector.
// Returns the addressed byte one cycle after a read and 00h otherwise. The
// index field is exposed only in alternate-access mode.
module lsc_read_mux
    import legacy_sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  port_sel_e         sel,
    input  logic              alt_access,
    input  logic [DATA_W-1:0] nmi_reg,
    input  logic [1:0]        sys_bits,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mux_d;

    // Pick the byte for the addressed port.
    always_comb begin
        mux_d = '0;
        unique case (sel)
            SEL_NMI:    mux_d = alt_access ? nmi_reg
                                           : {nmi_reg[DATA_W-1], {(DATA_W-1){1'b0}}};
            SEL_ALIAS:  mux_d = alt_access ? nmi_reg : '0;
            SEL_SYSCTL: mux_d = {{(DATA_W-2){1'b0}}, sys_bits};
            default:    mux_d = '0;
        endcase
    end

    // Capture read data for one cycle; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mux_d;
        else            rdata <= '0;
    end

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_SYSCTL) |=> (rdata[DATA_W-1:2] == '0));
endmodule

// File: rtl/legacy_sysctl_regs.sv
// Top of the legacy NMI / fast A20 / init register block.
// Decodes byte-wide I/O accesses at the NMI, alias and system control ports,
// and routes writes to the two register slices and reads through the mux.
// Assumes io_wr and io_rd are one-cycle strobes and never both high.
module legacy_sysctl_regs
    import legacy_sysctl_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    input  logic               alt_access,
    input  logic               nmi_raw,
    output logic               nmi_out,
    output logic [INDEX_W-1:0] rtc_index,
    output logic               rtc_index_wr,
    input  logic               a20_gate,
    output logic               a20m_n,
    output logic               init_n
);
    port_sel_e         sel;
    logic              wr_nmi;
    logic              wr_sys;
    logic [DATA_W-1:0] nmi_reg;
    logic [1:0]        sys_bits;

    // Decode the address; writes to the alias port are not routed.
    always_comb begin
        sel    = decode_port(io_addr);
        wr_nmi = io_wr && (sel == SEL_NMI);
        wr_sys = io_wr && (sel == SEL_SYSCTL);
    end

    lsc_nmi_index u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_nmi),
        .wdata    (io_wdata),
        .nmi_raw  (nmi_raw),
        .reg_q    (nmi_reg),
        .nmi_out  (nmi_out),
        .index_q  (rtc_index),
        .index_wr (rtc_index_wr)
    );

    lsc_fast_a20_init #(.PULSE_LEN(PULSE_LEN)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sys),
        .wdata    (io_wdata),
        .a20_gate (a20_gate),
        .bits_q   (sys_bits),
        .a20m_n   (a20m_n),
        .init_n   (init_n)
    );

    lsc_read_mux u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (io_rd),
        .sel        (sel),
        .alt_access (alt_access),
        .nmi_reg    (nmi_reg),
        .sys_bits   (sys_bits),
        .rdata      (io_rdata)
    );

    // R11
    alias_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel != SEL_NMI) |=> $stable(nmi_reg));
    // R11
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel != SEL_SYSCTL) |=> $stable(sys_bits));
    // R1
    reset_init_chk: assert property (@(posedge clk)
        !rst_n |=> init_n);
endmodule

// File: tb/legacy_sysctl_regs_tb.sv
module legacy_sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        alt_access = 1'b0;
    logic        nmi_raw = 1'b0;
    logic        nmi_out;
    logic [6:0]  rtc_index;
    logic        rtc_index_wr;
    logic        a20_gate = 1'b0;
    logic        a20m_n;
    logic        init_n;

    int n_chk = 0;
    int n_bad = 0;
    int low_cnt = 0;
    int fall_cnt = 0;
    logic init_prev = 1'b1;

    always #5 clk = ~clk;

    legacy_sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .alt_access(alt_access),
        .nmi_raw(nmi_raw), .nmi_out(nmi_out), .rtc_index(rtc_index),
        .rtc_index_wr(rtc_index_wr), .a20_gate(a20_gate), .a20m_n(a20m_n),
        .init_n(init_n)
    );

    // Count low cycles and falling edges of init_n at negedges.
    always @(negedge clk) begin
        if (!init_n) low_cnt++;
        if (init_prev && !init_n) fall_cnt++;
        init_prev = init_n;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        idle(3);
        check("R1 init_n in reset", int'(init_n), 1);
        rst_n = 1'b1;
        idle(2);
        check("R1 nmi_out", int'(nmi_out), 0);
        check("R1 init_n", int'(init_n), 1);
        alt_access = 1'b1;
        rd(16'h0070, d); check("R1 nmi byte", int'(d), 8'h80);
        alt_access = 1'b0;
        rd(16'h0092, d); check("R1 sysctl byte", int'(d), 0);
        idle(1);
        check("R12 idle rdata", int'(io_rdata), 0);

        // Sweep every NMI control byte.
        nmi_raw = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(16'h0070, 8'(v));
            check("R3 index", int'(rtc_index), v & 8'h7f);
            check("R3 strobe high", int'(rtc_index_wr), 1);
            @(negedge clk);
            check("R3 strobe one cycle", int'(rtc_index_wr), 0);
            check("R2 nmi_out", int'(nmi_out), ((v >> 7) & 1) ? 0 : 1);
            rd(16'h0070, d); check("R4 normal 70h", int'(d), v & 8'h80);
            rd(16'h0074, d); check("R4 normal 74h", int'(d), 0);
            alt_access = 1'b1;
            rd(16'h0070, d); check("R5 alt 70h", int'(d), v);
            rd(16'h0074, d); check("R5 alt 74h", int'(d), v);
            alt_access = 1'b0;
        end
        nmi_raw = 1'b0;
        idle(2);
        check("R2 nmi_raw low", int'(nmi_out), 0);

        // R11: alias and stray writes are ignored.
        wr(16'h0070, 8'h2a);
        wr(16'h0074, 8'hd5);
        wr(16'h0071, 8'hff);
        wr(16'h0093, 8'h03);
        alt_access = 1'b1;
        rd(16'h0070, d); check("R11 nmi byte kept", int'(d), 8'h2a);
        alt_access = 1'b0;
        rd(16'h0092, d); check("R11 sysctl kept", int'(d), 0);
        rd(16'h0090, d); check("R11 undecoded read", int'(d), 0);
        check("R11 no pulse", fall_cnt, 0);

        // Sweep every system control byte against both gate levels.
        for (int v = 0; v < 256; v++) begin
            wr(16'h0092, 8'(v));
            rd(16'h0092, d); check("R6 sysctl read", int'(d), v & 3);
            for (int g = 0; g < 2; g++) begin
                a20_gate = g[0];
                idle(2);
                check("R7 a20m_n", int'(a20m_n), g | ((v >> 1) & 1));
            end
        end
        // R7: gate change in the same cycle as an A20 write.
        @(negedge clk);
        io_addr = 16'h0092; io_wdata = 8'h02; io_wr = 1'b1; a20_gate = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
        @(negedge clk);
        check("R7 same-cycle", int'(a20m_n), 1);
        wr(16'h0092, 8'h00);
        idle(2);
        check("R7 both low", int'(a20m_n), 0);
        idle(20);

        // R8: single pulse length.
        low_cnt = 0; fall_cnt = 0;
        wr(16'h0092, 8'h01);
        check("R8 low after write", int'(init_n), 0);
        idle(25);
        check("R8 pulse length", low_cnt, 16);
        check("R8 one edge", fall_cnt, 1);

        // R9: rewrite of 1 starts nothing; clear then set starts one.
        low_cnt = 0; fall_cnt = 0;
        wr(16'h0092, 8'h01);
        idle(20);
        check("R9 no pulse on 1->1", fall_cnt, 0);
        wr(16'h0092, 8'h00);
        wr(16'h0092, 8'h01);
        idle(20);
        check("R9 second pulse", fall_cnt, 1);
        check("R9 second length", low_cnt, 16);

        // R10: 0-to-1 during a running pulse.
        wr(16'h0092, 8'h00);
        idle(2);
        low_cnt = 0; fall_cnt = 0;
        wr(16'h0092, 8'h01);
        idle(3);
        wr(16'h0092, 8'h00);
        wr(16'h0092, 8'h01);
        idle(25);
        check("R10 no restart", fall_cnt, 1);
        check("R10 no stretch", low_cnt, 16);

        check("R12 idle after reads", int'(io_rdata), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule